// File: doc/BRIEF.md
# Multi-Source Device Interrupt Status Unit

This block sits on the peripheral side of an interrupt path. It latches pulses from several event sources into a status word: source 0 is data arrival (receive done), source 1 is transmit done and source 2 is an error. Through a per-source enable mask it drives one level-sensitive interrupt line toward an interrupt controller. Software reaches the block through a small register bus. The bus has a read strobe, a write strobe and a word address. Read data comes back one cycle after the strobe, qualified by a valid pulse.

Software has three ways to clear a pending source. It can write ones to the status word, which clears those bits. It can read the data word, which retires the data-arrival source. It can write the acknowledge code, which retires everything pending at that moment. Status can always be read back. A handler therefore sees whether this device raised the line: the device is the cause only if some enabled bit is set. A read issued right after a clearing write sees the cleared state, so the handler can confirm the clear before it sends end-of-interrupt to the controller.

The bus has no back-pressure: every strobe is accepted in the cycle it is presented, and read and write strobes are not raised in the same cycle. Word addresses: 0 status, 1 enable mask, 2 acknowledge, 3 data.

Top module: `isu_top`

## Requirements
- R1: After reset the status word, the enable mask, the captured data word, the read data and the interrupt line are all zero.
- R2: A one on event input bit k (bit 0 data arrival, bit 1 transmit done, bit 2 error) sets status bit k at the next clock edge. The bit stays set until one of the clearing actions retires it.
- R3: A write to address 0 clears every status bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: Address 3 returns the word on the data input that was captured at the most recent source-0 event. A read of address 3 clears status bit 0 only. Writes to address 3 change nothing.
- R5: A write to address 2 whose data equals 0xA5 clears all status bits pending at that edge. A write of any other value changes nothing. Address 2 reads as zero. Events after the acknowledge latch again.
- R6: If an event on bit k arrives in the same cycle as any clear of bit k, bit k stays set.
- R7: The interrupt line is a register holding the OR of (status AND enable). It changes one cycle after status or enable changes, and it stays high while any enabled bit remains pending, even after some bits are cleared.
- R8: Address 1 is the read/write enable mask (low 3 bits, upper bits read zero). A masked pending bit still reads as set in the status word but does not raise the interrupt line.
- R9: Read data and the read-valid pulse appear in the cycle after the read strobe. A read issued in the cycle right after a clearing write returns the post-clear status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 3 | One-cycle event pulses, one bit per source |
| rx_word_i | input | 32 | Data word captured on a source-0 event |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| irq_o | output | 1 | Level interrupt request |

## Verification
A stuck or wrongly cleared status bit shows up at the port on the very next status read, one cycle after the strobe. A wrong mask or a wrong combine of status and mask shows up on the interrupt line within two cycles of the event or write that should change it. The stimulus collides events with each of the three clearing styles in the same cycle, so a lost event is seen on the read that follows. It also clears sources one at a time while the others stay pending, so a line that drops early is seen, and it masks pending bits so that status and line must disagree.

// File: rtl/isu_pkg.sv
package isu_pkg;

  typedef enum logic [1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_ACK  = 2'd2,
    REG_DATA = 2'd3
  } isu_reg_e;

  localparam int unsigned ISU_ACK_CODE = 32'h0000_00A5;

endpackage

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);

  // one flop per source; a set in the same cycle as a clear wins
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_o[g] <= 1'b0;
      end else if (set_i[g]) begin
        stat_o[g] <= 1'b1;
      end else if (clr_i[g]) begin
        stat_o[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/isu_regif.sv
module isu_regif
  import isu_pkg::*;
#(
  parameter int unsigned N        = 3,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 2,
  parameter int unsigned DATA_SRC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  evt_i,
  input  logic [DW-1:0] rx_word_i,
  input  logic [N-1:0]  stat_i,
  output logic [N-1:0]  clr_o,
  output logic [N-1:0]  en_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  localparam logic [N-1:0]  DATA_BIT = N'(1) << DATA_SRC;
  localparam logic [DW-1:0] ACK_VAL  = DW'(ISU_ACK_CODE);

  logic          hit_stat, hit_mask, hit_ack, hit_data;
  logic [N-1:0]  clr_w1c, clr_ack, clr_rd;
  logic [DW-1:0] data_q;
  logic [DW-1:0] rmux;

  assign hit_stat = (addr_i == AW'(REG_STAT));
  assign hit_mask = (addr_i == AW'(REG_MASK));
  assign hit_ack  = (addr_i == AW'(REG_ACK));
  assign hit_data = (addr_i == AW'(REG_DATA));

  // three independent clear paths, merged per bit
  always_comb begin
    clr_w1c = (wr_i && hit_stat) ? wdata_i[N-1:0] : '0;
    clr_ack = (wr_i && hit_ack && (wdata_i == ACK_VAL)) ? '1 : '0;
    clr_rd  = (rd_i && hit_data) ? DATA_BIT : '0;
    clr_o   = clr_w1c | clr_ack | clr_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= '0;
    end else if (wr_i && hit_mask) begin
      en_o <= wdata_i[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (evt_i[DATA_SRC]) begin
      data_q <= rx_word_i;
    end
  end

  always_comb begin
    rmux = '0;
    unique case (1'b1)
      hit_stat: rmux = DW'(stat_i);
      hit_mask: rmux = DW'(en_o);
      hit_data: rmux = data_q;
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) begin
        rdata_o <= rmux;
      end
    end
  end

endmodule

// File: rtl/isu_irq_out.sv
module isu_irq_out #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o <= 1'b0;
    end else begin
      irq_o <= |(stat_i & en_i);
    end
  end

endmodule

// File: rtl/isu_top.sv
module isu_top #(
  parameter int unsigned N        = 3,
  parameter int unsigned DW       = 32,
  parameter int unsigned AW       = 2,
  parameter int unsigned DATA_SRC = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  evt_i,
  input  logic [DW-1:0] rx_word_i,
  input  logic          bus_rd_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          bus_rvalid_o,
  output logic          irq_o
);

  logic [N-1:0] stat_w;
  logic [N-1:0] clr_w;
  logic [N-1:0] en_w;

  isu_regif #(
    .N(N), .DW(DW), .AW(AW), .DATA_SRC(DATA_SRC)
  ) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_i      (bus_rd_i),
    .wr_i      (bus_wr_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .evt_i     (evt_i),
    .rx_word_i (rx_word_i),
    .stat_i    (stat_w),
    .clr_o     (clr_w),
    .en_o      (en_w),
    .rdata_o   (bus_rdata_o),
    .rvalid_o  (bus_rvalid_o)
  );

  isu_status_bank #(.N(N)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_i),
    .clr_i  (clr_w),
    .stat_o (stat_w)
  );

  isu_irq_out #(.N(N)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat_i (stat_w),
    .en_i   (en_w),
    .irq_o  (irq_o)
  );

endmodule

// File: rtl/isu_chk.sv
module isu_chk #(
  parameter int unsigned N  = 3,
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt_i,
  input logic          bus_rd_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [DW-1:0] bus_rdata_o,
  input logic          bus_rvalid_o,
  input logic          irq_o,
  input logic [N-1:0]  stat_w,
  input logic [N-1:0]  en_w
);

  // R2 / R6
  evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((stat_w & $past(evt_i)) == $past(evt_i)));

  // R2
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_w & ~$past(stat_w) & ~$past(evt_i)) == '0));

  // R7
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == $past(|(stat_w & en_w)));

  // R9
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid_o == $past(bus_rd_i));

  // R5
  ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == AW'(2)) |=> (bus_rdata_o == '0));

endmodule

bind isu_top isu_chk #(.N(N), .DW(DW), .AW(AW)) u_isu_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .evt_i        (evt_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .bus_rvalid_o (bus_rvalid_o),
  .irq_o        (irq_o),
  .stat_w       (stat_w),
  .en_w         (en_w)
);

// File: tb/test_isu_top.sv
module test_isu_top;

  localparam int CLK_P = 10;
  localparam logic [1:0] A_STAT = 2'd0, A_MASK = 2'd1, A_ACK = 2'd2, A_DATA = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  evt_i = '0;
  logic [31:0] rx_word_i = '0;
  logic        bus_rd_i = 1'b0;
  logic        bus_wr_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        bus_rvalid_o;
  logic        irq_o;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  isu_top i_isu_top (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .rx_word_i(rx_word_i),
    .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .bus_rvalid_o(bus_rvalid_o), .irq_o(irq_o)
  );

  // scoreboard monitor: compares each returned read word with the queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_rvalid_o) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data actual=%h expected=none", bus_rdata_o);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata_o !== e) begin
          errors++;
          $display("FAIL %s read actual=%h expected=%h", t, bus_rdata_o, e);
        end
      end
    end
  end

  // all tasks start and end at a negedge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string t);
    bus_rd_i = 1'b1; bus_addr_i = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd_i = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] ev, input logic [31:0] w);
    evt_i = ev; rx_word_i = w;
    @(negedge clk);
    evt_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_o !== e) begin
      errors++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq_o, e);
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    errors++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk_irq(1'b0, "R1");
    rd(A_STAT, 32'h0, "R1");
    rd(A_MASK, 32'h0, "R1");
    rd(A_DATA, 32'h0, "R1");

    // R2 event latches; R8 masked bit shows in status, not on line
    pulse(3'b010, 32'h0);
    rd(A_STAT, 32'h2, "R2");
    idle(1);
    chk_irq(1'b0, "R8");

    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h7, "R8");
    chk_irq(1'b1, "R7");

    // R3 zero bits leave status alone; R9 read straight after clearing write
    wr(A_STAT, 32'h0);
    rd(A_STAT, 32'h2, "R3");
    wr(A_STAT, 32'h2);
    rd(A_STAT, 32'h0, "R9");
    chk_irq(1'b0, "R7");

    // R4 data read clears only bit 0
    pulse(3'b001, 32'h1234_5678);
    pulse(3'b100, 32'hDEAD_0000);
    rd(A_STAT, 32'h5, "R2");
    rd(A_DATA, 32'h1234_5678, "R4");
    rd(A_STAT, 32'h4, "R4");
    chk_irq(1'b1, "R7");
    wr(A_DATA, 32'h0000_FFFF);
    rd(A_DATA, 32'h1234_5678, "R4");
    rd(A_STAT, 32'h4, "R4");

    // R5 acknowledge
    wr(A_ACK, 32'h11);
    rd(A_STAT, 32'h4, "R5");
    wr(A_ACK, 32'hA5);
    rd(A_STAT, 32'h0, "R5");
    rd(A_ACK, 32'h0, "R5");
    chk_irq(1'b0, "R7");

    // R6 set wins over each clear style
    pulse(3'b010, 32'h0);
    evt_i = 3'b010;
    wr(A_STAT, 32'h2);
    evt_i = '0;
    rd(A_STAT, 32'h2, "R6");
    evt_i = 3'b100;
    wr(A_ACK, 32'hA5);
    evt_i = '0;
    rd(A_STAT, 32'h4, "R6");
    evt_i = 3'b001; rx_word_i = 32'hCAFE_F00D;
    rd(A_DATA, 32'h1234_5678, "R6");
    evt_i = '0;
    rd(A_STAT, 32'h5, "R6");
    rd(A_DATA, 32'hCAFE_F00D, "R4");

    // R8 partial masking; R7 line follows enabled bits only
    pulse(3'b001, 32'h0000_0042);
    wr(A_MASK, 32'h0);
    idle(1);
    chk_irq(1'b0, "R8");
    wr(A_MASK, 32'h4);
    idle(1);
    chk_irq(1'b1, "R8");
    wr(A_STAT, 32'h4);
    idle(1);
    chk_irq(1'b0, "R8");
    rd(A_STAT, 32'h1, "R8");

    // R5 events after acknowledge latch again
    wr(A_ACK, 32'hA5);
    pulse(3'b010, 32'h0);
    rd(A_STAT, 32'h2, "R5");
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9 missing read data actual=%0d expected=0 pending", exp_q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule